// File: doc/BRIEF.md
# Serial Configuration Port with Color Lookup Tables

This block is a three-wire serial slave that configures a display serializer and corrects its pixels. The host frames every transfer with an active-low chip select. It clocks bits in on the rising edge of the serial clock and uses one bidirectional data line, which appears here as an input, an output and an output enable. Behind the port sit three kinds of state:

- a small register file;
- three 256-entry by 8-bit color tables, one each for red, green and blue, each reached through an index register and a data register;
- two gates on writes: a device-select byte that must hold 0xFF, and a special-access bit that opens the dither and lane registers.

The register file drives the table-enable flag, the two dither configuration bytes and the lane code to the rest of the serializer. When the table is enabled, each color channel of a 24-bit pixel is replaced by its table entry. The port is only listened to while the pixel clock is stopped (`pix_run` low). A power-down request resets every register but leaves the table contents untouched.

Top module: `cfglut_top`

## Requirements
- R1: After reset the outputs are `lut_en`=0, `dith_cfg1`=0x60, `dith_cfg2`=0x67 and `lane_sel`=0x04. The device is locked, the table index registers are 0x00 and `spi_sdo_oe` is low.
- R2: While the select register (address 0x16) holds any value other than 0xFF, only writes to 0x16 take effect. Every other write is ignored, and a read returns 0x00 with `spi_sdo_oe` held low.
- R3: Writing 0xFF to 0x16 selects the device, and writing any value from 0x00 to 0xFE deselects it. A read of 0x16 while selected returns 0xFF.
- R4: Register 0x00 is readable and writable. Its bit 0 drives `lut_en` and its bit 4 is the special-access bit. Writes to 0x08 (`dith_cfg1`), 0x09 (`dith_cfg2`) and 0x0A (`lane_sel`) take effect only while bit 4 is 1.
- R5: While selected, a read of 0x08, 0x09, 0x0A or of an unassigned address (for example 0x01 or 0x0B) returns 0x00 on the data line, which is driven.
- R6: Addresses 0x02/0x03, 0x04/0x05 and 0x06/0x07 are the index and data registers of the red, green and blue tables. The index register is readable and writable. Each write or read at a data register accesses the entry the index points to and then adds one to the index. Data bytes that follow the address in one frame at a data register fill consecutive entries.
- R7: A table index advances from 255 to 0.
- R8: A write frame delivers at most 256 data bytes. Any further byte in the same frame is ignored.
- R9: With `lut_en`=1, `pix_out` one clock after `pix_in` is the red, green and blue table entries selected by `pix_in[23:16]`, `pix_in[15:8]` and `pix_in[7:0]`, placed in those same fields.
- R10: With `lut_en`=0, `pix_out` equals `pix_in` of the previous clock.
- R11: While `pix_run` is high the serial port ignores all traffic.
- R12: A clock with `pwr_dn` high returns every register to its R1 value, including the lock, and keeps the table contents.
- R13: A frame starts with a command bit (0 write, 1 read), followed by 7 address bits and then 8-bit data bytes, each sent most significant bit first. The slave drives the data line only during the 8 data bits of a selected read. The output enable is low during the header and once chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down request: resets registers, keeps tables |
| pix_run | input | 1 | High while the pixel clock runs; the serial port is ignored |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_scl | input | 1 | Serial clock, data sampled on its rising edge |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host during read data bits |
| spi_sdo_oe | output | 1 | Output enable for the shared data line |
| pix_in | input | 24 | Pixel in, red in [23:16], green [15:8], blue [7:0] |
| pix_out | output | 24 | Corrected or passed pixel, same field layout |
| lut_en | output | 1 | Table enable (register 0x00 bit 0) |
| dith_cfg1 | output | 8 | First dither configuration byte |
| dith_cfg2 | output | 8 | Second dither configuration byte |
| lane_sel | output | 8 | Lane code (0x04 three lanes, 0x02 two lanes) |

## Verification
Each serial line passes through a two-stage synchronizer, so the effect of a serial clock edge appears on the outputs three `clk` edges after that edge. The bench therefore holds each serial clock phase for six clocks. It samples the read data just before each rising serial clock edge, and it checks register outputs only after the frame has closed and chip select has been high for several clocks. The pixel path has exactly one register: the bench drives `pix_in` on a falling clock edge and compares `pix_out` at the next falling edge. Because every sweep changes the pixel on every cycle, an extra or missing stage is caught.

// File: rtl/cfglut_pkg.sv
package cfglut_pkg;
    localparam int NCOL   = 3;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam addr_t A_CMD     = 7'h00;
    localparam addr_t A_PORT_LO = 7'h02;
    localparam addr_t A_PORT_HI = 7'h07;
    localparam addr_t A_DITH1   = 7'h08;
    localparam addr_t A_DITH2   = 7'h09;
    localparam addr_t A_LANE    = 7'h0A;
    localparam addr_t A_SEL     = 7'h16;

    localparam byte_t SEL_KEY    = 8'hFF;
    localparam byte_t DITH1_INIT = 8'h60;
    localparam byte_t DITH2_INIT = 8'h67;
    localparam byte_t LANE_INIT  = 8'h04;

    localparam int CMD_LUT_BIT = 0;
    localparam int CMD_SRA_BIT = 4;

    typedef struct packed {
        byte_t                          sel;
        byte_t                          cmd;
        byte_t                          dith1;
        byte_t                          dith2;
        byte_t                          lane;
        logic [NCOL-1:0][BYTE_W-1:0]    ptr;
        addr_t                          fa;
    } regs_t;

    function automatic logic is_port(addr_t a);
        return (a >= A_PORT_LO) && (a <= A_PORT_HI);
    endfunction

    function automatic logic [1:0] port_of(addr_t a);
        addr_t o;
        o = (a - A_PORT_LO) >> 1;
        return o[1:0];
    endfunction
endpackage

// File: rtl/cfglut_spi_rx.sv
module cfglut_spi_rx
    import cfglut_pkg::*;
#(
    parameter int MAX_BYTES = 256,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  hold,
    input  logic  cs_n,
    input  logic  scl,
    input  logic  sdi,
    input  byte_t rd_data,
    input  logic  rd_drive,
    output logic  hdr_v,
    output logic  hdr_rd,
    output addr_t hdr_addr,
    output logic  byte_v,
    output byte_t byte_d,
    output logic  sdo,
    output logic  sdo_oe
);
    typedef struct packed {
        logic [1:0]       cs;
        logic [2:0]       ck;
        logic [1:0]       sd;
        logic [6:0]       sh;
        logic [2:0]       bitn;
        logic             hdr_ph;
        logic             rd;
        logic [CNT_W-1:0] nb;
        byte_t            rsh;
        logic             oe;
        logic [3:0]       rcnt;
    } rx_t;

    rx_t q, d;
    logic active, rise, fall, take;

    assign active   = !q.cs[1] && !hold;
    assign rise     = q.ck[1] && !q.ck[2];
    assign fall     = !q.ck[1] && q.ck[2];
    assign take     = active && rise;
    assign hdr_v    = take && q.hdr_ph && (q.bitn == 3'd7);
    assign hdr_rd   = q.sh[6];
    assign hdr_addr = {q.sh[5:0], q.sd[1]};
    assign byte_v   = take && !q.hdr_ph && !q.rd && (q.bitn == 3'd7)
                      && (q.nb != CNT_W'(MAX_BYTES));
    assign byte_d   = {q.sh, q.sd[1]};
    assign sdo      = q.oe & q.rsh[7];
    assign sdo_oe   = q.oe;

    always_comb begin
        d    = q;
        d.cs = {q.cs[0], cs_n};
        d.ck = {q.ck[1:0], scl};
        d.sd = {q.sd[0], sdi};
        if (!active) begin
            d.bitn   = '0;
            d.hdr_ph = 1'b1;
            d.rd     = 1'b0;
            d.nb     = '0;
            d.oe     = 1'b0;
            d.rcnt   = '0;
        end else if (rise) begin
            if (q.hdr_ph || !q.rd) begin
                d.sh   = {q.sh[5:0], q.sd[1]};
                d.bitn = q.bitn + 3'd1;
            end
            if (hdr_v) begin
                d.hdr_ph = 1'b0;
                d.rd     = hdr_rd;
                if (hdr_rd) begin
                    d.rsh = rd_data;
                    d.oe  = rd_drive;
                end
            end
            if (!q.hdr_ph && q.rd && (q.rcnt != 4'd8)) d.rcnt = q.rcnt + 4'd1;
            if (byte_v) d.nb = q.nb + CNT_W'(1);
        end else if (fall && q.oe) begin
            if (q.rcnt == 4'd8)      d.oe  = 1'b0;
            else if (q.rcnt != 4'd0) d.rsh = {q.rsh[6:0], 1'b0};
        end
        if (clr) begin
            d        = '0;
            d.cs     = '1;
            d.hdr_ph = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs     <= '1;
            q.hdr_ph <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfglut_regs.sv
module cfglut_regs
    import cfglut_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        hdr_v,
    input  logic                        hdr_rd,
    input  addr_t                       hdr_addr,
    input  logic                        byte_v,
    input  byte_t                       byte_d,
    input  logic [NCOL-1:0][BYTE_W-1:0] ram_rd,
    output byte_t                       rd_data,
    output logic                        rd_drive,
    output logic [NCOL-1:0]             ram_we,
    output logic [NCOL-1:0][BYTE_W-1:0] ram_idx,
    output byte_t                       ram_wd,
    output logic                        unlocked,
    output logic                        lut_en,
    output byte_t                       dith1,
    output byte_t                       dith2,
    output byte_t                       lane
);
    regs_t q, d;
    logic       sra;
    logic [1:0] rc, wc;

    assign unlocked = (q.sel == SEL_KEY);
    assign sra      = q.cmd[CMD_SRA_BIT];
    assign lut_en   = q.cmd[CMD_LUT_BIT];
    assign dith1    = q.dith1;
    assign dith2    = q.dith2;
    assign lane     = q.lane;
    assign ram_idx  = q.ptr;
    assign ram_wd   = byte_d;
    assign rd_drive = unlocked;
    assign rc       = port_of(hdr_addr);
    assign wc       = port_of(q.fa);

    always_comb begin
        rd_data = '0;
        if (unlocked) begin
            if (hdr_addr == A_CMD)       rd_data = q.cmd;
            else if (hdr_addr == A_SEL)  rd_data = q.sel;
            else if (is_port(hdr_addr))  rd_data = hdr_addr[0] ? ram_rd[rc] : q.ptr[rc];
        end
    end

    always_comb begin
        d      = q;
        ram_we = '0;
        if (hdr_v) begin
            d.fa = hdr_addr;
            if (hdr_rd && unlocked && is_port(hdr_addr) && hdr_addr[0])
                d.ptr[rc] = q.ptr[rc] + 8'd1;
        end
        if (byte_v) begin
            if (q.fa == A_SEL) begin
                d.sel = byte_d;
            end else if (unlocked) begin
                case (q.fa)
                    A_CMD:   d.cmd = byte_d;
                    A_DITH1: if (sra) d.dith1 = byte_d;
                    A_DITH2: if (sra) d.dith2 = byte_d;
                    A_LANE:  if (sra) d.lane  = byte_d;
                    default: begin
                        if (is_port(q.fa)) begin
                            if (q.fa[0]) begin
                                ram_we[wc] = 1'b1;
                                d.ptr[wc]  = q.ptr[wc] + 8'd1;
                            end else begin
                                d.ptr[wc]  = byte_d;
                            end
                        end
                    end
                endcase
            end
        end
        if (clr) begin
            d       = '0;
            d.dith1 = DITH1_INIT;
            d.dith2 = DITH2_INIT;
            d.lane  = LANE_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.dith1 <= DITH1_INIT;
            q.dith2 <= DITH2_INIT;
            q.lane  <= LANE_INIT;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cfglut_bank.sv
module cfglut_bank #(
    parameter int CW = 8,
    parameter int NC = 3,
    localparam int DEPTH = 1 << CW,
    localparam int PW = NC * CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NC-1:0]       we,
    input  logic [NC-1:0][CW-1:0] idx,
    input  logic [CW-1:0]       wd,
    output logic [NC-1:0][CW-1:0] rd,
    input  logic                lut_en,
    input  logic [PW-1:0]       pix_in,
    output logic [PW-1:0]       pix_out
);
    logic [PW-1:0] look;
    logic [PW-1:0] pix_d, pix_q;

    for (genvar g = 0; g < NC; g++) begin : g_col
        logic [CW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[idx[g]] <= wd;
        end

        assign rd[g] = mem[idx[g]];
        assign look[(NC-1-g)*CW +: CW] = mem[pix_in[(NC-1-g)*CW +: CW]];
    end

    always_comb begin
        pix_d = lut_en ? look : pix_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix_out = pix_q;
endmodule

// File: rtl/cfglut_top.sv
module cfglut_top
    import cfglut_pkg::*;
#(
    parameter int MAX_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_dn,
    input  logic        pix_run,
    input  logic        spi_cs_n,
    input  logic        spi_scl,
    input  logic        spi_sdi,
    output logic        spi_sdo,
    output logic        spi_sdo_oe,
    input  logic [23:0] pix_in,
    output logic [23:0] pix_out,
    output logic        lut_en,
    output logic [7:0]  dith_cfg1,
    output logic [7:0]  dith_cfg2,
    output logic [7:0]  lane_sel
);
    logic                        hdr_v, hdr_rd, byte_v, rd_drive, unlocked;
    addr_t                       hdr_addr;
    byte_t                       byte_d, rd_data, ram_wd;
    logic [NCOL-1:0]             ram_we;
    logic [NCOL-1:0][BYTE_W-1:0] ram_idx, ram_rd;

    cfglut_spi_rx #(.MAX_BYTES(MAX_BYTES)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .hold(pix_run),
        .cs_n(spi_cs_n), .scl(spi_scl), .sdi(spi_sdi),
        .rd_data(rd_data), .rd_drive(rd_drive),
        .hdr_v(hdr_v), .hdr_rd(hdr_rd), .hdr_addr(hdr_addr),
        .byte_v(byte_v), .byte_d(byte_d),
        .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
    );

    cfglut_regs regs_i (
        .clk(clk), .rst_n(rst_n), .clr(pwr_dn),
        .hdr_v(hdr_v), .hdr_rd(hdr_rd), .hdr_addr(hdr_addr),
        .byte_v(byte_v), .byte_d(byte_d), .ram_rd(ram_rd),
        .rd_data(rd_data), .rd_drive(rd_drive),
        .ram_we(ram_we), .ram_idx(ram_idx), .ram_wd(ram_wd),
        .unlocked(unlocked), .lut_en(lut_en),
        .dith1(dith_cfg1), .dith2(dith_cfg2), .lane(lane_sel)
    );

    cfglut_bank #(.CW(BYTE_W), .NC(NCOL)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .we(ram_we), .idx(ram_idx), .wd(ram_wd), .rd(ram_rd),
        .lut_en(lut_en), .pix_in(pix_in), .pix_out(pix_out)
    );
endmodule

// File: rtl/cfglut_checks.sv
module cfglut_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_dn,
    input logic        spi_cs_n,
    input logic        spi_sdo_oe,
    input logic        unlocked,
    input logic [23:0] pix_in,
    input logic [23:0] pix_out,
    input logic        lut_en,
    input logic [7:0]  dith_cfg1,
    input logic [7:0]  lane_sel
);
    // R13: with chip select high for three samples the line is released
    assert_quiet_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) |=> !spi_sdo_oe);

    // R2: the data line only starts driving when the device is selected
    assert_drive_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sdo_oe) |-> unlocked);

    // R2: locked device keeps its configuration outputs
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        !unlocked |=> $stable(lut_en) && $stable(dith_cfg1) && $stable(lane_sel));

    // R12: power-down restores defaults and the lock
    assert_pd_defaults_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_dn) |-> !lut_en && dith_cfg1 == 8'h60 && lane_sel == 8'h04 && !unlocked);

    // R10: bypass forwards the pixel with one register
    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!lut_en) |-> pix_out == $past(pix_in));
endmodule

bind cfglut_top cfglut_checks chk_i (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .spi_cs_n(spi_cs_n),
    .spi_sdo_oe(spi_sdo_oe), .unlocked(unlocked), .pix_in(pix_in),
    .pix_out(pix_out), .lut_en(lut_en), .dith_cfg1(dith_cfg1), .lane_sel(lane_sel)
);

// File: tb/cfglut_top_tb_top.sv
module cfglut_top_tb_top;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_dn = 1'b0, pix_run = 1'b0;
    logic spi_cs_n = 1'b1, spi_scl = 1'b0, spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe, lut_en;
    logic [23:0] pix_in = '0, pix_out;
    logic [7:0] dith_cfg1, dith_cfg2, lane_sel;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] mr [256];
    logic [7:0] mg [256];
    logic [7:0] mb [256];

    always #4 clk = ~clk;

    cfglut_top dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .pix_run(pix_run),
        .spi_cs_n(spi_cs_n), .spi_scl(spi_scl), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .pix_in(pix_in), .pix_out(pix_out), .lut_en(lut_en),
        .dith_cfg1(dith_cfg1), .dith_cfg2(dith_cfg2), .lane_sel(lane_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int i);
        case (k)
            0: return 8'(i * 7 + 3);
            1: return 8'(i ^ 'h5A);
            2: return 8'(255 - i);
            default: return 8'(i * 13 + 1);
        endcase
    endfunction

    task automatic sbit(input logic b);
        spi_sdi = b;
        tick(HALF);
        spi_scl = 1'b1;
        tick(HALF);
        spi_scl = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic close_frame();
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(3 * HALF);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] v);
        spi_cs_n = 1'b0;
        tick(HALF);
        sbyte({1'b0, a});
        sbyte(v);
        close_frame();
    endtask

    task automatic pw(input logic [6:0] a, input int n, input int k);
        spi_cs_n = 1'b0;
        tick(HALF);
        sbyte({1'b0, a});
        for (int i = 0; i < n; i++) sbyte(i >= 256 ? ~pat(k, i - 256) : pat(k, i));
        close_frame();
    endtask

    // read: value, any drive during header, drive on all data bits, drive on any data bit
    task automatic rd(input logic [6:0] a, output logic [7:0] v, output bit h_oe,
                      output bit all_oe, output bit any_oe);
        logic [7:0] hb;
        hb = {1'b1, a};
        h_oe = 0; all_oe = 1; any_oe = 0;
        spi_cs_n = 1'b0;
        tick(HALF);
        for (int i = 7; i >= 0; i--) begin
            spi_sdi = hb[i];
            tick(HALF);
            if (spi_sdo_oe) h_oe = 1;
            spi_scl = 1'b1;
            tick(HALF);
            spi_scl = 1'b0;
        end
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            v[i] = spi_sdo;
            if (spi_sdo_oe) any_oe = 1; else all_oe = 0;
            spi_scl = 1'b1;
            tick(HALF);
            spi_scl = 1'b0;
        end
        close_frame();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ho, ao, an;

        for (int i = 0; i < 256; i++) begin
            mr[i] = pat(0, i);
            mg[i] = pat(1, i);
            mb[i] = pat(2, i);
        end
        mg[255] = pat(3, 0);
        mg[0]   = pat(3, 1);

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk("R1 lut_en", lut_en, 0);
        chk("R1 dith_cfg1", dith_cfg1, 8'h60);
        chk("R1 dith_cfg2", dith_cfg2, 8'h67);
        chk("R1 lane_sel", lane_sel, 8'h04);
        chk("R1 sdo_oe", spi_sdo_oe, 0);

        // R2 locked device
        wr(7'h00, 8'h01);
        chk("R2 write ignored", lut_en, 0);
        rd(7'h16, v, ho, ao, an);
        chk("R2 locked read value", v, 0);
        chk("R2 locked read undriven", an, 0);

        // R3 select, deselect
        wr(7'h16, 8'hFF);
        rd(7'h16, v, ho, ao, an);
        chk("R3 select readback", v, 8'hFF);
        chk("R13 data bits driven", ao, 1);
        chk("R13 header undriven", ho, 0);
        chk("R13 released after frame", spi_sdo_oe, 0);
        wr(7'h16, 8'hFE);
        rd(7'h16, v, ho, ao, an);
        chk("R3 deselect value", v, 0);
        chk("R3 deselect undriven", an, 0);
        wr(7'h16, 8'hFF);

        // R4 special-access gate
        wr(7'h08, 8'h11);
        chk("R4 gated dith1", dith_cfg1, 8'h60);
        wr(7'h00, 8'h10);
        rd(7'h00, v, ho, ao, an);
        chk("R4 cmd readback", v, 8'h10);
        wr(7'h08, 8'h11);
        wr(7'h09, 8'h22);
        wr(7'h0A, 8'h02);
        chk("R4 dith1", dith_cfg1, 8'h11);
        chk("R4 dith2", dith_cfg2, 8'h22);
        chk("R4 lane", lane_sel, 8'h02);

        // R5 write-only and unassigned reads
        rd(7'h08, v, ho, ao, an);
        chk("R5 write-only value", v, 0);
        chk("R5 write-only driven", ao, 1);
        rd(7'h0A, v, ho, ao, an);
        chk("R5 lane read", v, 0);
        rd(7'h01, v, ho, ao, an);
        chk("R5 reserved 01", v, 0);
        rd(7'h0B, v, ho, ao, an);
        chk("R5 reserved 0B", v, 0);

        // R6 page fill of red and green tables
        wr(7'h02, 8'h00);
        pw(7'h03, 256, 0);
        rd(7'h02, v, ho, ao, an);
        chk("R6 red index after 256", v, 8'h00);
        wr(7'h04, 8'h00);
        pw(7'h05, 256, 1);
        wr(7'h02, 8'h10);
        rd(7'h03, v, ho, ao, an);
        chk("R6 red entry 0x10", v, mr[16]);
        rd(7'h02, v, ho, ao, an);
        chk("R6 read advances index", v, 8'h11);

        // R7 wrap of the green index
        wr(7'h04, 8'hFF);
        pw(7'h05, 2, 3);
        rd(7'h04, v, ho, ao, an);
        chk("R7 index wrapped", v, 8'h01);
        wr(7'h04, 8'hFF);
        rd(7'h05, v, ho, ao, an);
        chk("R7 entry 0xFF", v, mg[255]);
        rd(7'h05, v, ho, ao, an);
        chk("R7 entry 0x00", v, mg[0]);

        // R8 blue page with one byte too many
        wr(7'h06, 8'h00);
        pw(7'h07, 257, 2);
        rd(7'h06, v, ho, ao, an);
        chk("R8 index after 257 bytes", v, 8'h00);
        rd(7'h07, v, ho, ao, an);
        chk("R8 entry 0 kept", v, mb[0]);

        // R9 lookup sweep
        wr(7'h00, 8'h11);
        chk("R4 lut_en set", lut_en, 1);
        for (int i = 0; i < 256; i++) begin
            pix_in = {8'(i), 8'(255 - i), 8'(i ^ 'h33)};
            tick(1);
            chk("R9 lookup", pix_out, {mr[i], mg[255 - i], mb[i ^ 'h33]});
        end

        // R10 bypass sweep
        wr(7'h00, 8'h10);
        for (int i = 0; i < 64; i++) begin
            pix_in = 24'(i * 24'h030507 + 24'h102030);
            tick(1);
            chk("R10 bypass", pix_out, 24'(i * 24'h030507 + 24'h102030));
        end

        // R11 port ignored while pixel clock runs
        wr(7'h00, 8'h11);
        pix_run = 1'b1;
        wr(7'h00, 8'h00);
        pix_run = 1'b0;
        tick(2);
        chk("R11 write ignored", lut_en, 1);

        // R12 power-down
        pwr_dn = 1'b1;
        tick(3);
        pwr_dn = 1'b0;
        tick(2);
        chk("R12 lut_en", lut_en, 0);
        chk("R12 dith1", dith_cfg1, 8'h60);
        chk("R12 lane", lane_sel, 8'h04);
        rd(7'h16, v, ho, ao, an);
        chk("R12 relocked", an, 0);
        wr(7'h16, 8'hFF);
        wr(7'h00, 8'h01);
        pix_in = 24'h102030;
        tick(1);
        chk("R12 tables kept", pix_out, {mr[16], mg[32], mb[48]});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule